// File: doc/BRIEF.md
# Radio Receive Frame Readout Sequencer

This block sits between a packet radio's active-low interrupt line and a register-access port that reaches the radio's short and long register spaces. When the interrupt line falls, the block reads the radio's interrupt status register once. Reading that register clears it inside the radio, so both the receive flag and the transmit flag are taken from that single value.

For a receive event with reception armed, the block first masks the radio's receive interrupt. It then stops the radio from decoding further packets and drains the receive FIFO through the register port. The drain reads a length byte, then every frame byte, then a link-quality byte and a signal-strength byte. The frame bytes go out as a byte stream with the two trailing checksum bytes removed. The block then flushes the FIFO, lets the radio decode again, and pulses a completion output that carries the payload length, link quality and signal strength.

A transmit-complete flag in the same status value is reported on a separate pulse after any receive work. Address filtering and checksum validation stay inside the radio.

Top module: `radio_rx_drain`

## Requirements
- R1: While and right after synchronous reset, bus_req, pl_valid, rx_done and tx_done are 0, and rx_len, rx_lqi and rx_rssi are 0.
- R2: With the block idle, a falling edge on irq_n passes through two synchronising flops and then edge detection. The status read request (read, short space, address 0x031) is raised on the fourth rising clock edge after irq_n goes low.
- R3: A request holds bus_req, bus_wr, bus_long, bus_addr and bus_wdata unchanged until a cycle in which bus_ack is 1. Each request completes exactly one transaction.
- R4: When status bit 3 (receive) is set and rx_arm is 1 at the status read, the transactions run in this order: status read; write 0x08 to short 0x032 (receive interrupt masked); write 0x04 to short 0x039 (decode inhibited); long read 0x300 (length L); L long reads from 0x301 upward; long read 0x301+L (link quality); long read 0x302+L (signal strength); write 0x01 to short 0x00D (flush); write 0x00 to short 0x039. Long-space transactions are always reads.
- R5: Of the L frame bytes, the first L-2 appear on pl_data in FIFO order, one cycle with pl_valid for each. pl_valid is high in the cycle after the ack of the read that fetched the byte. The two checksum bytes are read but never emitted.
- R6: rx_done is a one-cycle pulse in the cycle after the ack of the final write to 0x039. In that cycle rx_len is L-2, rx_lqi is the byte from 0x301+L and rx_rssi is the byte from 0x302+L.
- R7: L is the low 7 bits of the length byte. When L is below 2, rx_len is 0 and no byte is emitted, yet all L frame reads still take place.
- R8: When status bit 3 is set but rx_arm is 0 at the status read, the only transaction after the status read is the flush write of 0x01 to 0x00D. No byte is emitted and there is no rx_done.
- R9: Status bit 0 (transmit) gives exactly one tx_done pulse. When bit 3 is also set, tx_done comes one cycle after rx_done. With bit 3 clear, the status read is the only transaction.
- R10: Falling edges on irq_n while an interrupt is being handled are ignored, so there is exactly one status read per handled interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Radio interrupt line, active low, asynchronous |
| rx_arm | input | 1 | Receive armed; when 0, received frames are flushed unread |
| bus_req | output | 1 | Register transaction request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_long | output | 1 | 1 = long address space, 0 = short |
| bus_addr | output | 10 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transaction complete; read data valid |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| pl_valid | output | 1 | Payload byte valid |
| pl_data | output | 8 | Payload byte |
| rx_done | output | 1 | Receive readout complete pulse |
| rx_len | output | 7 | Payload length without checksum |
| rx_lqi | output | 8 | Link-quality byte of the last frame |
| rx_rssi | output | 8 | Signal-strength byte of the last frame |
| tx_done | output | 1 | Transmit-complete pulse |

## Verification
A wrong sequencer state shows up at once on the register port as a missing, extra or misaddressed transaction. The bench therefore logs every transaction and compares the whole list against one computed from the status value, the arm input and the length. A wrong byte counter shows up within one frame as a payload of the wrong length, a checksum byte leaking out, or the trailer being read from the wrong address. Frame lengths are swept from 0 to 20, with further cases at 127 and with the top length bit set. A stuck-busy or prematurely idle state shows up as a second status read, or as a request that does not appear four edges after the interrupt falls.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_MASK, S_INHIB, S_LEN, S_BODY,
    S_LQI, S_RSSI, S_FLUSH, S_RESUME, S_FIN
  } seq_state_t;

  typedef struct packed {
    logic              wr;
    logic              lng;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } bus_cmd_t;
endpackage

// File: rtl/rrd_irq_sync.sv
module rrd_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_n,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      last <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], line_n};
      last <= sh[STAGES-1];
    end
  end

  assign fall = last & ~sh[STAGES-1];
endmodule

// File: rtl/rrd_fsm.sv
module rrd_fsm import rrd_pkg::*; #(
  parameter int                LEN_W      = 7,
  parameter int                RX_BIT     = 3,
  parameter int                TX_BIT     = 0,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 10'h031,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 10'h032,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 10'h039,
  parameter logic [ADDR_W-1:0] FLUSH_ADDR = 10'h00D,
  parameter logic [ADDR_W-1:0] FIFO_BASE  = 10'h300,
  parameter logic [DATA_W-1:0] MASK_VAL   = 8'h08,
  parameter logic [DATA_W-1:0] INHIB_VAL  = 8'h04,
  parameter logic [DATA_W-1:0] FLUSH_VAL  = 8'h01,
  parameter logic [DATA_W-1:0] RESUME_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              rx_arm,
  output logic              bus_req,
  output bus_cmd_t          cmd_q,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              pl_valid,
  output logic [DATA_W-1:0] pl_data,
  output logic              rx_done,
  output logic [LEN_W-1:0]  rx_len,
  output logic [DATA_W-1:0] rx_lqi,
  output logic [DATA_W-1:0] rx_rssi,
  output logic              tx_done
);
  seq_state_t        state;
  bus_cmd_t          cmd_d;
  logic              flag_rx, flag_tx;
  logic [LEN_W-1:0]  flen, idx, pay_n;
  logic [DATA_W-1:0] lqi_q, rssi_q;

  // checksum occupies the last two frame bytes
  assign pay_n = (flen >= LEN_W'(2)) ? flen - LEN_W'(2) : '0;

  always_comb begin
    cmd_d = '0;
    case (state)
      S_STAT:   cmd_d = '{wr: 1'b0, lng: 1'b0, addr: STAT_ADDR,  wdata: '0};
      S_MASK:   cmd_d = '{wr: 1'b1, lng: 1'b0, addr: MASK_ADDR,  wdata: MASK_VAL};
      S_INHIB:  cmd_d = '{wr: 1'b1, lng: 1'b0, addr: CTRL_ADDR,  wdata: INHIB_VAL};
      S_LEN:    cmd_d = '{wr: 1'b0, lng: 1'b1, addr: FIFO_BASE,  wdata: '0};
      S_BODY:   cmd_d = '{wr: 1'b0, lng: 1'b1,
                          addr: FIFO_BASE + ADDR_W'(idx) + ADDR_W'(1), wdata: '0};
      S_LQI:    cmd_d = '{wr: 1'b0, lng: 1'b1,
                          addr: FIFO_BASE + ADDR_W'(flen) + ADDR_W'(1), wdata: '0};
      S_RSSI:   cmd_d = '{wr: 1'b0, lng: 1'b1,
                          addr: FIFO_BASE + ADDR_W'(flen) + ADDR_W'(2), wdata: '0};
      S_FLUSH:  cmd_d = '{wr: 1'b1, lng: 1'b0, addr: FLUSH_ADDR, wdata: FLUSH_VAL};
      S_RESUME: cmd_d = '{wr: 1'b1, lng: 1'b0, addr: CTRL_ADDR,  wdata: RESUME_VAL};
      default:  cmd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bus_req  <= 1'b0;
      cmd_q    <= '0;
      flag_rx  <= 1'b0;
      flag_tx  <= 1'b0;
      flen     <= '0;
      idx      <= '0;
      lqi_q    <= '0;
      rssi_q   <= '0;
      pl_valid <= 1'b0;
      pl_data  <= '0;
      rx_done  <= 1'b0;
      rx_len   <= '0;
      rx_lqi   <= '0;
      rx_rssi  <= '0;
      tx_done  <= 1'b0;
    end else begin
      pl_valid <= 1'b0;
      rx_done  <= 1'b0;
      tx_done  <= 1'b0;
      case (state)
        S_IDLE: if (fall) state <= S_STAT;
        S_FIN: begin
          tx_done <= flag_tx;
          state   <= S_IDLE;
        end
        default: begin
          if (!bus_req) begin
            bus_req <= 1'b1;
            cmd_q   <= cmd_d;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            case (state)
              S_STAT: begin
                flag_rx <= bus_rdata[RX_BIT];
                flag_tx <= bus_rdata[TX_BIT];
                if (!bus_rdata[RX_BIT]) state <= S_FIN;
                else if (rx_arm)        state <= S_MASK;
                else                    state <= S_FLUSH;
              end
              S_MASK:  state <= S_INHIB;
              S_INHIB: state <= S_LEN;
              S_LEN: begin
                flen  <= bus_rdata[LEN_W-1:0];
                idx   <= '0;
                state <= (bus_rdata[LEN_W-1:0] == '0) ? S_LQI : S_BODY;
              end
              S_BODY: begin
                if (idx < pay_n) begin
                  pl_valid <= 1'b1;
                  pl_data  <= bus_rdata;
                end
                idx <= idx + LEN_W'(1);
                if (idx == flen - LEN_W'(1)) state <= S_LQI;
              end
              S_LQI:  begin lqi_q  <= bus_rdata; state <= S_RSSI;  end
              S_RSSI: begin rssi_q <= bus_rdata; state <= S_FLUSH; end
              S_FLUSH: begin
                // an unarmed frame is discarded by the flush alone
                state <= (cmd_q.addr == FLUSH_ADDR && flen_path_armed()) ? S_RESUME : S_FIN;
              end
              S_RESUME: begin
                rx_done <= 1'b1;
                rx_len  <= pay_n;
                rx_lqi  <= lqi_q;
                rx_rssi <= rssi_q;
                state   <= S_FIN;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // armed path recorded by having passed the inhibit write this interrupt
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst || state == S_IDLE) armed_q <= 1'b0;
    else if (state == S_INHIB)  armed_q <= 1'b1;
  end

  function automatic logic flen_path_armed();
    return armed_q & flag_rx;
  endfunction
endmodule

// File: rtl/radio_rx_drain.sv
module radio_rx_drain import rrd_pkg::*; #(
  parameter int LEN_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_n,
  input  logic              rx_arm,
  output logic              bus_req,
  output logic              bus_wr,
  output logic              bus_long,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              pl_valid,
  output logic [DATA_W-1:0] pl_data,
  output logic              rx_done,
  output logic [LEN_W-1:0]  rx_len,
  output logic [DATA_W-1:0] rx_lqi,
  output logic [DATA_W-1:0] rx_rssi,
  output logic              tx_done
);
  logic     fall;
  bus_cmd_t cmd_q;

  rrd_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_n(irq_n), .fall(fall)
  );

  rrd_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .fall(fall), .rx_arm(rx_arm),
    .bus_req(bus_req), .cmd_q(cmd_q), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .pl_valid(pl_valid), .pl_data(pl_data), .rx_done(rx_done), .rx_len(rx_len),
    .rx_lqi(rx_lqi), .rx_rssi(rx_rssi), .tx_done(tx_done)
  );

  assign bus_wr    = cmd_q.wr;
  assign bus_long  = cmd_q.lng;
  assign bus_addr  = cmd_q.addr;
  assign bus_wdata = cmd_q.wdata;
endmodule

// File: rtl/rrd_chk.sv
module rrd_chk import rrd_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_wr,
  input logic              bus_long,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              pl_valid,
  input logic              rx_done,
  input logic              tx_done
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable({bus_wr, bus_long, bus_addr, bus_wdata}));

  assert_long_is_read_R4: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_long |-> !bus_wr);

  assert_byte_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    pl_valid |-> $past(bus_ack) && !$past(rst));

  assert_done_after_write_R6: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(bus_ack && bus_wr) && !$past(rst));

  assert_rx_tx_apart_R9: assert property (@(posedge clk) disable iff (rst)
    !(rx_done && tx_done));
endmodule

bind radio_rx_drain rrd_chk u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack), .bus_wr(bus_wr),
  .bus_long(bus_long), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pl_valid(pl_valid), .rx_done(rx_done), .tx_done(tx_done)
);

// File: tb/tb_radio_rx_drain.sv
`timescale 1ns/1ps
module tb_radio_rx_drain;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_n = 1'b1;
  logic rx_arm = 1'b0;
  logic bus_req, bus_wr, bus_long, bus_ack;
  logic [9:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, pl_data, rx_lqi, rx_rssi;
  logic pl_valid, rx_done, tx_done;
  logic [6:0] rx_len;

  always #2 clk = ~clk;

  radio_rx_drain dut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .rx_arm(rx_arm),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_long(bus_long), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .pl_valid(pl_valid), .pl_data(pl_data), .rx_done(rx_done), .rx_len(rx_len),
    .rx_lqi(rx_lqi), .rx_rssi(rx_rssi), .tx_done(tx_done)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0]  fifo [0:255];
  logic [7:0]  stat_val = 8'h00;
  logic [19:0] log_e [0:2047];
  logic [19:0] exp_e [0:299];
  int log_n = 0, stat_n = 0, exp_n = 0, wcnt = 0;
  logic [7:0] pl_a [0:2047];
  int pl_n = 0, rxd_n = 0, txd_n = 0, rx_cyc = 0, tx_cyc = 0;
  logic [6:0] cap_len;
  logic [7:0] cap_lqi, cap_rssi;

  function automatic logic [7:0] mread(input logic lng, input logic [9:0] a);
    if (lng && a >= 10'h300) return fifo[a - 10'h300];
    if (!lng && a == 10'h031) return stat_val;
    return 8'h00;
  endfunction

  // radio register model with varying latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 8'h00;
      wcnt      <= 0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (wcnt >= log_n % 3) begin
          bus_ack   <= 1'b1;
          wcnt      <= 0;
          bus_rdata <= mread(bus_long, bus_addr);
          log_e[log_n] <= {bus_wr, bus_long, bus_addr, bus_wr ? bus_wdata : 8'h00};
          log_n <= log_n + 1;
          if (!bus_wr && !bus_long && bus_addr == 10'h031) stat_n <= stat_n + 1;
        end else wcnt <= wcnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pl_valid) begin pl_a[pl_n] = pl_data; pl_n = pl_n + 1; end
      if (rx_done) begin
        rxd_n = rxd_n + 1; rx_cyc = cyc;
        cap_len = rx_len; cap_lqi = rx_lqi; cap_rssi = rx_rssi;
      end
      if (tx_done) begin txd_n = txd_n + 1; tx_cyc = cyc; end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    bad = bad + 1; total = total + 1;
    $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic add(input bit wr, input bit lng, input int a, input int d);
    exp_e[exp_n] = {wr, lng, 10'(a), 8'(d)};
    exp_n = exp_n + 1;
  endtask

  task automatic run_case(input logic [7:0] st, input bit arm, input logic [7:0] lb,
                          input int seed, input bit glitch);
    int lb0, pb, rb, tb, sb, n, quiet, mis, L, P;
    for (int i = 0; i < 256; i++) fifo[i] = 8'((i * 13 + seed) & 255);
    fifo[0] = lb;
    stat_val = st;
    rx_arm = arm;
    L = int'(lb & 8'h7f);
    P = (L >= 2) ? L - 2 : 0;
    exp_n = 0;
    add(0, 0, 'h031, 0);
    if (st[3]) begin
      if (arm) begin
        add(1, 0, 'h032, 'h08); add(1, 0, 'h039, 'h04); add(0, 1, 'h300, 0);
        for (int i = 0; i < L; i++) add(0, 1, 'h301 + i, 0);
        add(0, 1, 'h301 + L, 0); add(0, 1, 'h302 + L, 0);
        add(1, 0, 'h00D, 'h01); add(1, 0, 'h039, 'h00);
      end else add(1, 0, 'h00D, 'h01);
    end
    @(negedge clk);
    lb0 = log_n; pb = pl_n; rb = rxd_n; tb = txd_n; sb = stat_n;
    irq_n = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_req);
    chk(n == 4, "R2 request delay", n, 4);
    chk(bus_addr == 10'h031 && !bus_wr && !bus_long, "R2 status read", int'(bus_addr), 'h031);
    while (stat_n == sb) @(negedge clk);
    irq_n = 1'b1;
    if (glitch) begin
      while (log_n < lb0 + 5) @(negedge clk);
      irq_n = 1'b0; repeat (2) @(negedge clk); irq_n = 1'b1;
    end
    quiet = 0;
    while (quiet < 12) begin @(negedge clk); quiet = bus_req ? 0 : quiet + 1; end
    // transcript: R4 armed order, R8 unarmed, R9 status only
    mis = -1;
    if (log_n - lb0 != exp_n) mis = 1000 + log_n - lb0;
    else for (int i = 0; i < exp_n; i++) if (mis < 0 && log_e[lb0 + i] != exp_e[i]) mis = i;
    chk(mis < 0, st[3] ? (arm ? "R4 transaction order" : "R8 flush only") : "R9 status only",
        mis, -1);
    chk(stat_n - sb == 1, "R10 one status read", stat_n - sb, 1);
    chk(pl_n - pb == ((st[3] && arm) ? P : 0), "R5 R7 payload count", pl_n - pb,
        (st[3] && arm) ? P : 0);
    mis = -1;
    for (int k = 0; k < pl_n - pb; k++) if (mis < 0 && pl_a[pb + k] != fifo[1 + k]) mis = k;
    chk(mis < 0, "R5 payload bytes", mis, -1);
    chk(rxd_n - rb == ((st[3] && arm) ? 1 : 0), "R6 R8 rx_done count", rxd_n - rb,
        (st[3] && arm) ? 1 : 0);
    if (st[3] && arm) begin
      chk(int'(cap_len) == P, "R6 R7 rx_len", int'(cap_len), P);
      chk(cap_lqi == fifo[1 + L], "R6 rx_lqi", int'(cap_lqi), int'(fifo[1 + L]));
      chk(cap_rssi == fifo[2 + L], "R6 rx_rssi", int'(cap_rssi), int'(fifo[2 + L]));
    end
    chk(txd_n - tb == (st[0] ? 1 : 0), "R9 tx_done count", txd_n - tb, st[0] ? 1 : 0);
    if (st[0] && st[3] && arm) chk(tx_cyc == rx_cyc + 1, "R9 tx after rx", tx_cyc - rx_cyc, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(!bus_req && !pl_valid && !rx_done && !tx_done && rx_len == 0 && rx_lqi == 0
        && rx_rssi == 0, "R1 reset outputs", int'(bus_req), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !rx_done && !tx_done, "R1 idle after reset", int'(bus_req), 0);
    for (int len = 0; len <= 20; len++) run_case(8'h08, 1'b1, 8'(len), len * 5, 1'b0);
    run_case(8'h08, 1'b1, 8'h85, 3, 1'b0);
    run_case(8'h08, 1'b1, 8'd127, 9, 1'b0);
    run_case(8'h09, 1'b1, 8'd6, 21, 1'b0);
    run_case(8'h01, 1'b1, 8'd6, 22, 1'b0);
    run_case(8'h00, 1'b1, 8'd6, 23, 1'b0);
    run_case(8'h08, 1'b0, 8'd9, 24, 1'b0);
    run_case(8'h09, 1'b0, 8'd9, 25, 1'b0);
    run_case(8'h09, 1'b1, 8'd30, 26, 1'b1);
    summary();
  end
endmodule